// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Emulator

This block models a small serial EEPROM that a processor drives by bit-banging. The processor writes one memory-mapped register to set chip select, serial clock and serial data in. It reads the same register to sample serial data out. Behind the register, a protocol engine detects edges on chip select and the serial clock. It frames a start bit, a two-bit opcode and an eight-bit word address, then runs the selected command against an internal array of 256 sixteen-bit words. Each word is held as two bytes, high byte first.

The command set covers locking and unlocking writes, filling or wiping the whole array, reading one word, writing one word and setting one word to all ones. A single-word write is committed only on the next rising edge of chip select. Read data leaves the device on falling edges of the serial clock. A write-enable latch, cleared at reset, guards every change to the array.

Top module: `tw_eeprom_port`

## Requirements
- R1: After reset, data out reads 1 and writing is disabled. Array contents are not cleared by reset.
- R2: Only bus writes whose address bits 7:4 equal 8 reach the engine. Chip select is data bit 7, serial clock is bit 6 and data in is bit 1. A read at such an address returns data out in bit 0 with zeros above it. A read at any other address returns 0xFF.
- R3: A chip-select rising edge in the write state stores the low 16 shift bits to the addressed word when writing is enabled. It also sets the shift register to all ones, so data out reads 1, and enters the null state. A chip-select rising edge in any other state enters idle.
- R4: In idle, a clock rising edge with data in high is the start bit. It is followed by 2 opcode bits and 8 address bits, each most significant bit first and sampled on clock rising edges.
- R5: Opcode 00 with address bits 7:6 = 11 enables writing, and with 00 disables it. Both take effect at the last address bit and return to the null state.
- R6: Opcode 00 with address bits 7:6 = 01 takes 16 data bits and then sets every word to that data, if writing is enabled.
- R7: Opcode 00 with address bits 7:6 = 10 takes 16 bits and then sets every word to 0xFFFF, if writing is enabled.
- R8: Opcode 01 takes 16 data bits, most significant first, and waits in the write state for the commit of R3.
- R9: Opcode 10 needs one further clock rising edge, which loads the word and makes data out 0. Each of the next 16 clock falling edges presents the next data bit, most significant first. After the 16th falling edge the engine returns to the null state.
- R10: Opcode 11 takes 16 bits and replaces them with 0xFFFF. The commit of R3 then sets the addressed word to 0xFFFF.
- R11: While writing is disabled, single-word writes, fills, wipes and word erases leave the array unchanged.
- R12: In the null state, clock edges have no effect until a chip-select rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 8 | Bus address (read and write) |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational from the address |

## Verification
Every bus write is registered on the rising edge that sees the strobe. Its effect on data out is readable in the cycle right after that edge, and a read at a non-matching address answers 0xFF at once. The scoreboard driver presents each read address on a falling edge and queues the value the requirement predicts. The monitor compares 2 ns after the following rising edge, so each sample lands one full register stage after the write it depends on and never on an edge.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;
    localparam int OPC_W  = 2;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BYTES  = 2 * DEPTH;
    localparam int SR_W   = WORD_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int BUS_W  = 8;

    typedef enum logic [3:0] {
        ST_NULL, ST_IDLE, ST_OPC, ST_ADR,
        ST_MISC, ST_WCOL, ST_RDLD, ST_FCOL,
        ST_WRITE, ST_READ
    } ph_e;

    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_WIPE   = 2'b10,
        SUB_UNLOCK = 2'b11
    } sub_e;

    typedef struct packed {
        logic cs_rise;
        logic sk_rise;
        logic sk_fall;
        logic di;
    } pin_ev_t;

    typedef struct packed {
        logic              one;
        logic              all;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } st_req_t;

    function automatic ph_e opc_phase(input logic [OPC_W-1:0] op);
        case (op)
            2'b00:   return ST_MISC;
            2'b01:   return ST_WCOL;
            2'b10:   return ST_RDLD;
            default: return ST_FCOL;
        endcase
    endfunction

    function automatic logic shifts_on_rise(input ph_e s);
        return (s != ST_NULL) && (s != ST_IDLE) && (s != ST_READ);
    endfunction
endpackage

// File: rtl/tw_pin_latch.sv
module tw_pin_latch
    import tw_eeprom_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    stb,
    input  logic    cs_in,
    input  logic    sk_in,
    input  logic    di_in,
    output pin_ev_t ev
);
    logic cs_q, sk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= 1'b0;
            sk_q <= 1'b0;
        end else if (stb) begin
            cs_q <= cs_in;
            sk_q <= sk_in;
        end
    end

    always_comb begin
        ev.cs_rise = stb && cs_in && !cs_q;
        ev.sk_rise = stb && sk_in && !sk_q;
        ev.sk_fall = stb && !sk_in && sk_q;
        ev.di      = di_in;
    end
endmodule

// File: rtl/tw_word_store.sv
module tw_word_store
    import tw_eeprom_pkg::*;
(
    input  logic              clk,
    input  st_req_t           req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int BYTE_W = WORD_W / 2;
    localparam int IDX_W  = ADDR_W + 1;

    logic [BYTE_W-1:0] mem [BYTES];

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        localparam logic [ADDR_W-1:0] WORD_IDX = ADDR_W'(b / 2);
        localparam bit HIGH_HALF = (b % 2) == 0;
        logic sel;
        assign sel = req.all || (req.one && req.addr == WORD_IDX);
        always_ff @(posedge clk) begin
            if (sel) begin
                if (HIGH_HALF) mem[b] <= req.data[WORD_W-1:BYTE_W];
                else           mem[b] <= req.data[BYTE_W-1:0];
            end
        end
    end

    logic [IDX_W-1:0] hi_idx, lo_idx;
    assign hi_idx  = {rd_addr, 1'b0};
    assign lo_idx  = {rd_addr, 1'b1};
    assign rd_word = {mem[hi_idx], mem[lo_idx]};
endmodule

// File: rtl/tw_proto_fsm.sv
module tw_proto_fsm
    import tw_eeprom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev,
    input  logic [WORD_W-1:0] rd_word,
    output st_req_t           req,
    output ph_e               ph_q,
    output logic [SR_W-1:0]   sr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [ADDR_W-1:0] adr_q,
    output logic              wen_q
);
    localparam logic [CNT_W-1:0] N_OPC  = CNT_W'(OPC_W);
    localparam logic [CNT_W-1:0] N_ADR  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] N_WORD = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] N_ONE  = CNT_W'(1);

    ph_e               ph_n;
    logic [SR_W-1:0]   sr_n;
    logic [CNT_W-1:0]  cnt_n;
    logic [ADDR_W-1:0] adr_n;
    logic [OPC_W-1:0]  opc_q, opc_n;
    logic              wen_n;
    sub_e              sub_new, sub_cur;

    assign sub_cur = sub_e'(adr_q[ADDR_W-1 -: 2]);

    always_comb begin
        ph_n     = ph_q;
        sr_n     = sr_q;
        cnt_n    = cnt_q;
        adr_n    = adr_q;
        opc_n    = opc_q;
        wen_n    = wen_q;
        req      = '0;
        req.addr = adr_q;
        req.data = sr_q[WORD_W-1:0];
        sub_new  = sub_e'(sr_q[ADDR_W-2 -: 2]);

        // chip select rising: commit or re-arm
        if (ev.cs_rise) begin
            if (ph_q == ST_WRITE) begin
                req.one = wen_q;
                sr_n    = '1;
                ph_n    = ST_NULL;
            end else begin
                ph_n = ST_IDLE;
            end
        end

        if (ev.sk_rise) begin
            if (shifts_on_rise(ph_n)) begin
                sr_n = {sr_n[SR_W-2:0], ev.di};
                if (cnt_n < N_WORD) cnt_n = cnt_n + 1'b1;
            end
            sub_new = sub_e'(sr_n[ADDR_W-1 -: 2]);
            case (ph_n)
                ST_IDLE: begin
                    if (ev.di) begin
                        ph_n  = ST_OPC;
                        cnt_n = '0;
                        sr_n  = '0;
                    end
                end
                ST_OPC: begin
                    if (cnt_n == N_OPC) begin
                        ph_n  = ST_ADR;
                        cnt_n = '0;
                        opc_n = sr_n[OPC_W-1:0];
                    end
                end
                ST_ADR: begin
                    if (cnt_n == N_ADR) begin
                        cnt_n = '0;
                        adr_n = sr_n[ADDR_W-1:0];
                        ph_n  = opc_phase(opc_n);
                        if (opc_n == '0) begin
                            if (sub_new == SUB_LOCK) begin
                                wen_n = 1'b0;
                                ph_n  = ST_NULL;
                            end else if (sub_new == SUB_UNLOCK) begin
                                wen_n = 1'b1;
                                ph_n  = ST_NULL;
                            end
                        end
                    end
                end
                ST_MISC: begin
                    if (cnt_n == N_WORD) begin
                        cnt_n = '0;
                        case (sub_cur)
                            SUB_FILL: begin
                                ph_n     = ST_WRITE;
                                req.all  = wen_q;
                                req.data = sr_n[WORD_W-1:0];
                            end
                            SUB_WIPE: begin
                                ph_n     = ST_WRITE;
                                req.all  = wen_q;
                                req.data = '1;
                            end
                            SUB_LOCK: begin
                                wen_n = 1'b0;
                                ph_n  = ST_NULL;
                            end
                            default: begin
                                wen_n = 1'b1;
                                ph_n  = ST_NULL;
                            end
                        endcase
                    end
                end
                ST_WCOL: begin
                    if (cnt_n == N_WORD) begin
                        cnt_n = '0;
                        ph_n  = ST_WRITE;
                    end
                end
                ST_RDLD: begin
                    if (cnt_n == N_ONE) begin
                        sr_n  = {1'b0, rd_word};
                        cnt_n = '0;
                        ph_n  = ST_READ;
                    end
                end
                ST_FCOL: begin
                    if (cnt_n == N_WORD) begin
                        sr_n  = {1'b0, {WORD_W{1'b1}}};
                        cnt_n = '0;
                        ph_n  = ST_WRITE;
                    end
                end
                default: ;
            endcase
        end else if (ev.sk_fall && ph_n == ST_READ) begin
            sr_n  = {sr_n[SR_W-2:0], 1'b0};
            cnt_n = cnt_n + 1'b1;
            if (cnt_n == N_WORD) begin
                cnt_n = '0;
                ph_n  = ST_NULL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= ST_NULL;
            sr_q  <= '1;
            cnt_q <= '0;
            adr_q <= '0;
            opc_q <= '0;
            wen_q <= 1'b0;
        end else begin
            ph_q  <= ph_n;
            sr_q  <= sr_n;
            cnt_q <= cnt_n;
            adr_q <= adr_n;
            opc_q <= opc_n;
            wen_q <= wen_n;
        end
    end
endmodule

// File: rtl/tw_eeprom_port.sv
module tw_eeprom_port
    import tw_eeprom_pkg::*;
#(
    parameter logic [3:0] BASE_NIB = 4'h8,
    parameter int         CS_BIT   = 7,
    parameter int         SK_BIT   = 6,
    parameter int         DI_BIT   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    logic              reg_hit;
    pin_ev_t           pin_ev;
    st_req_t           st_req;
    ph_e               ph;
    logic [SR_W-1:0]   sr;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] word_adr;
    logic              wen;
    logic [WORD_W-1:0] rd_word;
    logic              dout;

    assign reg_hit = bus_addr[BUS_W-1 -: 4] == BASE_NIB;

    tw_pin_latch u_pins (
        .clk   (clk),
        .rst   (rst),
        .stb   (bus_wr && reg_hit),
        .cs_in (bus_wdata[CS_BIT]),
        .sk_in (bus_wdata[SK_BIT]),
        .di_in (bus_wdata[DI_BIT]),
        .ev    (pin_ev)
    );

    tw_proto_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (pin_ev),
        .rd_word (rd_word),
        .req     (st_req),
        .ph_q    (ph),
        .sr_q    (sr),
        .cnt_q   (cnt),
        .adr_q   (word_adr),
        .wen_q   (wen)
    );

    tw_word_store u_store (
        .clk     (clk),
        .req     (st_req),
        .rd_addr (word_adr),
        .rd_word (rd_word)
    );

    assign dout      = sr[SR_W-1];
    assign bus_rdata = reg_hit ? {{(BUS_W-1){1'b0}}, dout} : {BUS_W{1'b1}};
endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk
    import tw_eeprom_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             hit,
    input pin_ev_t          ev,
    input st_req_t          req,
    input ph_e              ph,
    input logic [SR_W-1:0]  sr,
    input logic [CNT_W-1:0] cnt,
    input logic             wen
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sr[SR_W-1] && !wen));

    assert_foreign_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !hit) |=> ($stable(ph) && $stable(sr) && $stable(wen)));

    assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
        (ph == ST_WRITE && ev.cs_rise) |=> (ph == ST_NULL && sr == '1));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORD_W));

    assert_read_window_R9: assert property (@(posedge clk) disable iff (rst)
        (ph == ST_READ) |-> (cnt < CNT_W'(WORD_W)));

    assert_protect_R11: assert property (@(posedge clk) disable iff (rst)
        (req.one || req.all) |-> wen);

    assert_null_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (ph == ST_NULL && !ev.cs_rise) |=> (ph == ST_NULL));
endmodule

bind tw_eeprom_port tw_eeprom_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .bus_wr (bus_wr),
    .hit    (reg_hit),
    .ev     (pin_ev),
    .req    (st_req),
    .ph     (ph),
    .sr     (sr),
    .cnt    (cnt),
    .wen    (wen)
);

// File: tb/sim_tw_eeprom_port.sv
module sim_tw_eeprom_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    always #5 clk = ~clk;

    tw_eeprom_port u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    logic [15:0] model [256];
    bit          wen_m = 0;

    // monitor: compare one queued item per cycle, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = a;
        sb.push_back('{exp: e, tag: tag});
    endtask

    task automatic expect_do(input logic e, input string tag);
        expect_rd(8'h80, {7'b0, e}, tag);
    endtask

    task automatic wr_at(input logic [7:0] a, input logic cs, input logic sk, input logic di);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = {cs, sk, 4'b0000, di, 1'b0};
    endtask

    task automatic wr_reg(input logic cs, input logic sk, input logic di);
        wr_at(8'h80, cs, sk, di);
    endtask

    task automatic clk_bit(input logic di);
        wr_reg(1'b1, 1'b0, di);
        wr_reg(1'b1, 1'b1, di);
    endtask

    task automatic select_rise();
        wr_reg(1'b0, 1'b0, 1'b0);
        wr_reg(1'b1, 1'b0, 1'b0);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [7:0] a);
        select_rise();
        clk_bit(1'b1);
        for (int i = 1; i >= 0; i--) clk_bit(op[i]);
        for (int i = 7; i >= 0; i--) clk_bit(a[i]);
    endtask

    task automatic send_word(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) clk_bit(d[i]);
    endtask

    task automatic commit_chk();
        select_rise();
        expect_do(1'b1, "R3 data out high after commit");
    endtask

    task automatic op_enable();
        send_hdr(2'b00, 8'hC0);
        wen_m = 1;
    endtask

    task automatic op_disable();
        send_hdr(2'b00, 8'h00);
        wen_m = 0;
    endtask

    task automatic op_write(input logic [7:0] a, input logic [15:0] d);
        send_hdr(2'b01, a);
        send_word(d);
        commit_chk();
        if (wen_m) model[a] = d;
    endtask

    task automatic op_fill(input logic [15:0] d);
        send_hdr(2'b00, 8'h40);
        send_word(d);
        if (wen_m) for (int i = 0; i < 256; i++) model[i] = d;
        commit_chk();
    endtask

    task automatic op_wipe();
        send_hdr(2'b00, 8'h80);
        send_word(16'hFFFF);
        if (wen_m) for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
        commit_chk();
    endtask

    task automatic op_erase(input logic [7:0] a);
        send_hdr(2'b11, a);
        send_word(16'h1357);
        commit_chk();
        if (wen_m) model[a] = 16'hFFFF;
    endtask

    task automatic op_read(input logic [7:0] a, input bit noise, input string tag);
        logic [15:0] w;
        w = model[a];
        send_hdr(2'b10, a);
        clk_bit(1'b0);
        expect_do(1'b0, "R9 dummy zero after load");
        for (int i = 15; i >= 0; i--) begin
            wr_reg(1'b1, 1'b0, 1'b0);
            if (noise) begin
                wr_at(8'h40, 1'b1, 1'b1, 1'b1);
                wr_at(8'h40, 1'b0, 1'b0, 1'b0);
                expect_rd(8'h70, 8'hFF, "R2 foreign read");
            end
            expect_do(w[i], tag);
            wr_reg(1'b1, 1'b1, 1'b0);
        end
        wr_reg(1'b1, 1'b0, 1'b0);
        expect_do(w[0], "R12 null ignores clock after read");
    endtask

    task automatic do_reset();
        @(negedge clk);
        bus_wr = 1'b0;
        rst    = 1'b1;
        repeat (2) @(negedge clk);
        rst    = 1'b0;
        wen_m  = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        expect_do(1'b1, "R1 data out after reset");
        expect_rd(8'h30, 8'hFF, "R2 other address reads FF");

        op_enable();                               // R5
        op_wipe();                                 // R7
        op_read(8'h00, 0, "R7 wiped word 00");
        op_read(8'hFF, 0, "R7 wiped word FF");

        op_write(8'h12, 16'hA5C3);                 // R8
        op_write(8'h13, 16'h0001);
        op_read(8'h12, 0, "R8 word 12 readback");
        op_read(8'h13, 1, "R2 R9 read with foreign writes");

        op_fill(16'h6B2D);                         // R6
        op_read(8'h00, 0, "R6 fill word 00");
        op_read(8'hFE, 0, "R6 fill word FE");

        op_erase(8'h21);                           // R10
        op_read(8'h21, 0, "R10 erased word");
        op_read(8'h22, 0, "R10 neighbour kept");

        op_disable();                              // R5
        op_write(8'h22, 16'h1111);
        op_fill(16'h0000);
        op_erase(8'h22);
        op_wipe();
        op_read(8'h22, 0, "R11 locked array unchanged");

        op_enable();
        do_reset();
        expect_do(1'b1, "R1 data out after second reset");
        op_write(8'h30, 16'h0000);
        op_read(8'h30, 0, "R1 write disabled after reset");

        @(negedge clk);
        bus_wr = 1'b0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule